// File: doc/BRIEF.md
# Gate and Power-Good Override Controller

This block sits between the normal gate-control decision for an external power switch and the pins that leave the chip. It passes the normal gate request and the normal power-good through, and applies three overrides on top of them. A hot-side manual reset pin, active low, forces the gate off. A cold-side manual reset pin, active high, forces power-good high and leaves the gate alone. A software shutdown register, written one byte at a time, can also force the gate off.

Both manual pins are first brought into the clock domain by a synchronizer chain. Each then has to hold its active level for a programmable number of clock cycles before it takes effect, which sets the minimum pulse width. The shutdown override is armed by one byte value and released by another. It is also released when the qualified hot-side reset is asserted. The register's stored byte can always be read back, and it returns to zero whenever the block is reset.

Top module: `gate_ovr_ctrl`

## Requirements
- R1: After reset the readback is 8'h00, no override is active, `gate_en_o` equals `gate_req_i` and `pgood_o` equals `pgood_i`. The gate output is never high while the gate request is low.
- R2: With SYNC_STAGES = 2, a low level on `hot_rst_n_i` that is first seen at a clock edge forces `gate_en_o` low after exactly 2 + QUAL_CYCLES edges, counting that edge. One edge earlier the gate still follows the request.
- R3: If `hot_rst_n_i` returns high before the count completes, the count restarts from zero. Repeated low pulses of QUAL_CYCLES-1 edges, separated by short high gaps, never force the gate off.
- R4: Once `hot_rst_n_i` goes high again, the hot-side override drops after 3 edges (sync depth plus one), and the gate follows the request again.
- R5: A high level on `cold_rst_i` forces `pgood_o` high after 2 + QUAL_CYCLES edges. The override drops 3 edges after the pin returns low.
- R6: The cold-side override has no effect on `gate_en_o`. The gate keeps following the request while power-good is forced.
- R7: A register write of 8'hAA arms the shutdown. From the next clock edge, `gate_en_o` is low whatever the request.
- R8: A register write of 8'h00 releases the shutdown. From the next edge, the gate follows the request.
- R9: A qualified hot-side reset releases an armed shutdown without changing the stored byte. After the hot pin is released, the gate follows the request.
- R10: A write of any byte other than 8'hAA or 8'h00 is stored but leaves the shutdown state as it was (armed stays armed, released stays released).
- R11: `reg_rdata_o` shows the last byte written, from the edge after the write. The stored byte is volatile: any reset returns it to 8'h00.
- R12: `pgood_o` is high whenever `pgood_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| gate_req_i | input | 1 | Gate request from the normal control logic |
| pgood_i | input | 1 | Power-good from the normal monitor |
| hot_rst_n_i | input | 1 | Hot-side manual reset pin, active low, asynchronous |
| cold_rst_i | input | 1 | Cold-side manual reset pin, active high, asynchronous |
| reg_wr_i | input | 1 | One-cycle write strobe for the shutdown register |
| reg_wdata_i | input | DATA_W | Byte written to the shutdown register |
| gate_en_o | output | 1 | Final switch gate enable |
| pgood_o | output | 1 | Final power-good |
| reg_rdata_o | output | DATA_W | Readback of the shutdown register |

## Verification
The properties assume that the write strobe and write data are synchronous to `clk` and stay stable around the edge. They also assume that `gate_req_i` and `pgood_i` come from logic in the same clock domain; only the two manual pins may change at any time. The stimulus drives every input just after the falling edge, so each sample taken at the next rising edge is unambiguous. The manual pins are held for counted numbers of edges, so the qualification and restart boundaries fall on known cycles.

// File: rtl/gate_ovr_pkg.sv
package gate_ovr_pkg;

   localparam int unsigned DEF_DATA_W      = 8;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   localparam int unsigned DEF_QUAL_CYCLES = 625;   // 5 us at 125 MHz

   // Decoded meaning of a shutdown-register write
   typedef enum logic [1:0] {
      SD_CMD_NONE  = 2'd0,
      SD_CMD_ARM   = 2'd1,
      SD_CMD_CLEAR = 2'd2,
      SD_CMD_KEEP  = 2'd3
   } sd_cmd_e;

endpackage

// File: rtl/gate_ovr_sync.sv
module gate_ovr_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gate_ovr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gate_ovr_qual.sv
module gate_ovr_qual #(
   parameter int unsigned CYCLES     = 625,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic qual_o
);

   localparam int unsigned CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("gate_ovr_qual: CYCLES must be at least 1");
   end

   logic             active;
   logic [CNT_W-1:0] cnt_q;

   if (ACTIVE_LOW) begin : g_act_low
      assign active = ~level_i;
   end else begin : g_act_high
      assign active = level_i;
   end

   // Streak counter: restarts on any inactive cycle, saturates at the limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!active)          cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign qual_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/gate_ovr_sdreg.sv
module gate_ovr_sdreg
   import gate_ovr_pkg::*;
#(
   parameter int unsigned          DATA_W   = 8,
   parameter logic [DATA_W-1:0]    ARM_CODE = 8'hAA,
   parameter logic [DATA_W-1:0]    CLR_CODE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              hot_rel_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              force_o
);

   if (ARM_CODE == CLR_CODE) begin : g_bad_codes
      $error("gate_ovr_sdreg: arm and clear codes must differ");
   end

   sd_cmd_e           cmd;
   logic [DATA_W-1:0] store_q;
   logic              force_q;

   always_comb begin
      if (!wr_i)                    cmd = SD_CMD_NONE;
      else if (wdata_i == ARM_CODE) cmd = SD_CMD_ARM;
      else if (wdata_i == CLR_CODE) cmd = SD_CMD_CLEAR;
      else                          cmd = SD_CMD_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    store_q <= '0;
      else if (wr_i) store_q <= wdata_i;
   end

   // Hot-side release dominates an arming write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    force_q <= 1'b0;
      else if (hot_rel_i)            force_q <= 1'b0;
      else if (cmd == SD_CMD_ARM)    force_q <= 1'b1;
      else if (cmd == SD_CMD_CLEAR)  force_q <= 1'b0;
   end

   assign rdata_o = store_q;
   assign force_o = force_q;

endmodule

// File: rtl/gate_ovr_ctrl.sv
module gate_ovr_ctrl
   import gate_ovr_pkg::*;
#(
   parameter int unsigned       DATA_W        = DEF_DATA_W,
   parameter int unsigned       SYNC_STAGES   = DEF_SYNC_STAGES,
   parameter int unsigned       QUAL_CYCLES   = DEF_QUAL_CYCLES,
   parameter logic [DATA_W-1:0] SHUTDOWN_CODE = DATA_W'(8'hAA),
   parameter logic [DATA_W-1:0] CLEAR_CODE    = DATA_W'(8'h00)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_req_i,
   input  logic              pgood_i,
   input  logic              hot_rst_n_i,
   input  logic              cold_rst_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic              gate_en_o,
   output logic              pgood_o,
   output logic [DATA_W-1:0] reg_rdata_o
);

   if (DATA_W < 8) begin : g_bad_width
      $error("gate_ovr_ctrl: DATA_W must hold the 8-bit command codes");
   end

   logic hot_sync;
   logic cold_sync;
   logic hot_qual;
   logic cold_qual;
   logic sd_force;

   // Hot-side pin: idles high, qualified while low
   gate_ovr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hot_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (hot_rst_n_i),
      .q_o   (hot_sync)
   );

   gate_ovr_qual #(.CYCLES(QUAL_CYCLES), .ACTIVE_LOW(1'b1)) u_hot_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (hot_sync),
      .qual_o  (hot_qual)
   );

   // Cold-side pin: idles low, qualified while high
   gate_ovr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cold_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cold_rst_i),
      .q_o   (cold_sync)
   );

   gate_ovr_qual #(.CYCLES(QUAL_CYCLES), .ACTIVE_LOW(1'b0)) u_cold_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (cold_sync),
      .qual_o  (cold_qual)
   );

   gate_ovr_sdreg #(
      .DATA_W   (DATA_W),
      .ARM_CODE (SHUTDOWN_CODE),
      .CLR_CODE (CLEAR_CODE)
   ) u_sdreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr_i),
      .wdata_i   (reg_wdata_i),
      .hot_rel_i (hot_qual),
      .rdata_o   (reg_rdata_o),
      .force_o   (sd_force)
   );

   assign gate_en_o = gate_req_i & ~hot_qual & ~sd_force;
   assign pgood_o   = pgood_i | cold_qual;

endmodule

// File: rtl/gate_ovr_chk.sv
module gate_ovr_chk #(
   parameter int unsigned       DATA_W   = 8,
   parameter logic [DATA_W-1:0] ARM_CODE = 8'hAA,
   parameter logic [DATA_W-1:0] CLR_CODE = 8'h00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gate_req_i,
   input logic              pgood_i,
   input logic              reg_wr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic              gate_en_o,
   input logic              pgood_o,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              hot_q,
   input logic              cold_q,
   input logic              sd_force
);

   AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en_o |-> gate_req_i); // R1

   AST_HOT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      hot_q |-> !gate_en_o); // R2

   AST_COLD_PGOOD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cold_q |-> pgood_o); // R5

   AST_COLD_GATE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_req_i && !hot_q && !sd_force) |-> gate_en_o); // R6

   AST_ARM_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_wdata_i == ARM_CODE && !hot_q) |=> !gate_en_o); // R7

   AST_FORCE_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sd_force |-> !gate_en_o); // R7

   AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_wdata_i == CLR_CODE) |=> !sd_force); // R8

   AST_HOT_CLEARS_SD: assert property (@(posedge clk) disable iff (!rst_n)
      hot_q |=> !sd_force); // R9

   AST_OTHER_KEEPS_SD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_wdata_i != ARM_CODE && reg_wdata_i != CLR_CODE && !hot_q)
      |=> (sd_force == $past(sd_force))); // R10

   AST_READBACK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i |=> (reg_rdata_o == $past(reg_wdata_i))); // R11

   AST_READBACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_i |=> $stable(reg_rdata_o)); // R11

   AST_PGOOD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_i |-> pgood_o); // R12

endmodule

bind gate_ovr_ctrl gate_ovr_chk #(
   .DATA_W   (DATA_W),
   .ARM_CODE (SHUTDOWN_CODE),
   .CLR_CODE (CLEAR_CODE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gate_req_i  (gate_req_i),
   .pgood_i     (pgood_i),
   .reg_wr_i    (reg_wr_i),
   .reg_wdata_i (reg_wdata_i),
   .gate_en_o   (gate_en_o),
   .pgood_o     (pgood_o),
   .reg_rdata_o (reg_rdata_o),
   .hot_q       (hot_qual),
   .cold_q      (cold_qual),
   .sd_force    (sd_force)
);

// File: tb/tb_gate_ovr_ctrl.sv
`timescale 1ns/1ps
module tb_gate_ovr_ctrl;

   localparam int unsigned QUAL = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gate_req = 1'b0;
   logic       pgood = 1'b0;
   logic       hot_n = 1'b1;
   logic       cold = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       gate_en;
   logic       pg_out;
   logic [7:0] rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gate_ovr_ctrl #(.QUAL_CYCLES(QUAL)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .gate_req_i  (gate_req),
      .pgood_i     (pgood),
      .hot_rst_n_i (hot_n),
      .cold_rst_i  (cold),
      .reg_wr_i    (wr),
      .reg_wdata_i (wdata),
      .gate_en_o   (gate_en),
      .pgood_o     (pg_out),
      .reg_rdata_o (rdata)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // n rising edges, then settle on the falling edge
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic reg_write(input logic [7:0] v);
      wr = 1'b1; wdata = v;
      tick(1);
      wr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic t_reset();
      hot_n = 1'b1; cold = 1'b0; gate_req = 1'b0; pgood = 1'b0;
      do_reset();
      chk("R11 reset readback", rdata, 8'h00);
      chk("R1 gate low when no request", gate_en, 1'b0);
      chk("R1 pgood follows low", pg_out, 1'b0);
      gate_req = 1'b1; pgood = 1'b1;
      tick(1);
      chk("R1 gate follows request", gate_en, 1'b1);
      chk("R12 pgood passes high", pg_out, 1'b1);
      pgood = 1'b0;
      tick(1);
      chk("R1 pgood follows low again", pg_out, 1'b0);
   endtask

   task automatic t_hot_qualify();
      gate_req = 1'b1;
      hot_n = 1'b0;
      tick(1 + QUAL);
      chk("R2 gate still on one edge early", gate_en, 1'b1);
      tick(1);
      chk("R2 gate off after qualification", gate_en, 1'b0);
      tick(5);
      chk("R2 gate held off", gate_en, 1'b0);
      hot_n = 1'b1;
      tick(2);
      chk("R4 still off before release done", gate_en, 1'b0);
      tick(1);
      chk("R4 gate back after release", gate_en, 1'b1);
   endtask

   task automatic t_hot_restart();
      bit ok = 1'b1;
      gate_req = 1'b1;
      for (int p = 0; p < 3; p++) begin
         hot_n = 1'b0;
         for (int c = 0; c < int'(QUAL) - 1; c++) begin
            tick(1);
            if (gate_en !== 1'b1) ok = 1'b0;
         end
         hot_n = 1'b1;
         for (int c = 0; c < 2; c++) begin
            tick(1);
            if (gate_en !== 1'b1) ok = 1'b0;
         end
      end
      tick(4);
      chk("R3 short pulses never qualify", {31'd0, ok}, 32'd1);
      chk("R3 gate on after short pulses", gate_en, 1'b1);
   endtask

   task automatic t_cold();
      gate_req = 1'b1; pgood = 1'b0;
      cold = 1'b1;
      tick(1 + QUAL);
      chk("R5 pgood low one edge early", pg_out, 1'b0);
      tick(1);
      chk("R5 pgood forced high", pg_out, 1'b1);
      chk("R6 gate unaffected by cold", gate_en, 1'b1);
      gate_req = 1'b0;
      tick(1);
      chk("R6 gate still follows request", gate_en, 1'b0);
      gate_req = 1'b1;
      cold = 1'b0;
      tick(2);
      chk("R5 pgood held before release", pg_out, 1'b1);
      tick(1);
      chk("R5 pgood released", pg_out, 1'b0);
      pgood = 1'b1;
      tick(1);
      chk("R12 pgood passes after release", pg_out, 1'b1);
      pgood = 1'b0;
   endtask

   task automatic t_sd_arm_clear();
      gate_req = 1'b1;
      reg_write(8'hAA);
      chk("R7 gate off after arm write", gate_en, 1'b0);
      chk("R11 readback AA", rdata, 8'hAA);
      tick(3);
      chk("R7 gate stays off", gate_en, 1'b0);
      reg_write(8'h00);
      chk("R8 gate back after clear", gate_en, 1'b1);
      chk("R11 readback 00", rdata, 8'h00);
   endtask

   task automatic t_sd_other();
      gate_req = 1'b1;
      reg_write(8'hAA);
      reg_write(8'h5A);
      chk("R10 armed stays armed", gate_en, 1'b0);
      chk("R11 readback 5A", rdata, 8'h5A);
      reg_write(8'h00);
      reg_write(8'h33);
      chk("R10 released stays released", gate_en, 1'b1);
      chk("R11 readback 33", rdata, 8'h33);
      reg_write(8'hAB);
      chk("R10 near-code leaves gate on", gate_en, 1'b1);
   endtask

   task automatic t_sd_hot_release();
      gate_req = 1'b1;
      reg_write(8'hAA);
      chk("R9 armed before hot reset", gate_en, 1'b0);
      hot_n = 1'b0;
      tick(QUAL + 4);
      hot_n = 1'b1;
      tick(3);
      chk("R9 hot reset released shutdown", gate_en, 1'b1);
      chk("R9 stored byte kept", rdata, 8'hAA);
   endtask

   task automatic t_volatile();
      reg_write(8'hC3);
      chk("R11 readback C3", rdata, 8'hC3);
      do_reset();
      chk("R11 cleared by reset", rdata, 8'h00);
      gate_req = 1'b1;
      tick(1);
      chk("R1 no override after reset", gate_en, 1'b1);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      t_reset();
      t_hot_qualify();
      t_hot_restart();
      t_cold();
      t_sd_arm_clear();
      t_sd_other();
      t_sd_hot_release();
      t_volatile();
      done = 1'b1;
      report();
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

endmodule